// File: doc/BRIEF.md
# In-Path Signal Fault Injector

This block sits in series on two monitored signals, a single-bit flag and a signed integer, and corrupts what passes through while a programmed fault is live. It is placed between a producer and a consumer during validation runs so that the tolerance logic downstream can be exercised without changing either side. When no fault is live the two outputs are the inputs, in the same cycle and through logic only, so the path gains no register stage.

A small set of write-only registers chooses one effect for each channel, the effect operands, a start cycle, a length and whether the fault stops after its length or lasts for the rest of the run. Both channels share one timing window, so one programmed set can corrupt the flag and the integer together. The effects cover inversion, forced values, freezing, a condition-gated force, noise, gain, offset, a growing drift, pseudo-random values and a pure delay. Pseudo-random values come from an internal 16-bit shift-register generator.

Top module: `sig_saboteur`

## Requirements
- R1: While no fault is live (outside the window, or the channel's enable bit is clear), `b_out` equals `b_in` and `i_out` equals `i_in` in the same cycle.
- R2: A cycle counter is 0 from reset release until the first clock edge and then counts edges; with mode transient a fault is live exactly while start <= count < start + length, so pass-through returns in the cycle after the last live one.
- R3: With mode permanent a fault is live for every cycle with count >= start, until new settings are written.
- R4: Flag effects by code: 0 gives the inverted input; 1 gives operand A bit 0; 3 gives operand A bit 0 while `cond_in` is 1 and the input while it is 0.
- R5: Flag effect 2 outputs, for the whole live period, the input value present in its first live cycle.
- R6: Flag effect 4 outputs bit 0 of the pseudo-random generator, independent of the input.
- R7: Effect delay (flag code 5, integer code 8) outputs the input of D cycles earlier, D taken from the delay register and limited to 16; D = 0 is pass-through.
- R8: Integer code 0 outputs operand A; code 4 outputs input + A; sums clip to the signed integer range instead of wrapping.
- R9: Integer code 1 outputs floor(input * A / 256), A read as signed fixed point with 8 fraction bits, clipped to the signed range.
- R10: Integer code 3 (drift): in the k-th live cycle (k from 0) the output is input + (k+1)*A, with the accumulated term and the sum clipped; the accumulated term restarts at each new live period.
- R11: Codes 2, 5 and 7 draw a value P in [A, B] as A + (R mod (B - A + 1)), R being the 16-bit generator state (taps at bits 15, 13, 12, 10, non-zero seed, one step per cycle); code 7 outputs P, code 5 outputs input + P, code 2 applies P as a gain as in R9; if B < A then P = A.
- R12: Integer code 6 outputs, for the whole live period, the input value present in its first live cycle.
- R13: The flag and the integer channel share one window: with both enabled, both are corrupted in exactly the same cycles.
- R14: Register map by `cfg_addr`: 0 control (bit 0 flag enable, bit 1 integer enable, bit 2 permanent, bits 6:4 flag code, bits 11:8 integer code), 1 start, 2 length, 3 operand A, 4 operand B, 5 delay; a write with `cfg_we` takes effect at that clock edge; undefined codes pass through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 32 | Register write data |
| cond_in | input | 1 | Condition for the gated force effect |
| b_in | input | 1 | Flag channel input |
| b_out | output | 1 | Flag channel output |
| i_in | input | IW (16) | Integer channel input, signed |
| i_out | output | IW (16) | Integer channel output, signed |

## Verification
The bench walks the window edges cycle by cycle, so a design that opened or closed the window one cycle off, or kept corrupting after a transient expired, shows a mismatch on the first or last cycle. Gain and offset are swept across negative odd values and the range ends; a design that rounded toward zero instead of down, or wrapped instead of clipping, gives wrong values there. Delays beyond the buffer depth check that the length is limited rather than reduced modulo, and drift is compared term by term to catch an accumulator that starts at zero output or never restarts. Random effects are checked against their bounds on every cycle, which catches a modulo that overshoots the range or a generator stuck at one value.

// File: rtl/sab_pkg.sv
package sab_pkg;

    typedef enum logic [2:0] {
        BFX_INVERT   = 3'd0,
        BFX_FORCE    = 3'd1,
        BFX_HOLD     = 3'd2,
        BFX_FORCE_IF = 3'd3,
        BFX_NOISE    = 3'd4,
        BFX_DELAY    = 3'd5
    } bfx_e;

    typedef enum logic [3:0] {
        IFX_CONST      = 4'd0,
        IFX_GAIN       = 4'd1,
        IFX_GAIN_RND   = 4'd2,
        IFX_DRIFT      = 4'd3,
        IFX_OFFSET     = 4'd4,
        IFX_OFFSET_RND = 4'd5,
        IFX_HOLD       = 4'd6,
        IFX_RANDOM     = 4'd7,
        IFX_DELAY      = 4'd8
    } ifx_e;

    localparam logic [2:0] ADDR_CTRL  = 3'd0;
    localparam logic [2:0] ADDR_START = 3'd1;
    localparam logic [2:0] ADDR_LEN   = 3'd2;
    localparam logic [2:0] ADDR_OPA   = 3'd3;
    localparam logic [2:0] ADDR_OPB   = 3'd4;
    localparam logic [2:0] ADDR_DELAY = 3'd5;

    typedef struct packed {
        logic en_b;
        logic en_i;
        logic perm;
        bfx_e bfx;
        ifx_e ifx;
    } ctrl_t;

    function automatic ctrl_t decode_ctrl(input logic [11:0] w);
        ctrl_t c;
        c.en_b = w[0];
        c.en_i = w[1];
        c.perm = w[2];
        c.bfx  = bfx_e'(w[6:4]);
        c.ifx  = ifx_e'(w[11:8]);
        return c;
    endfunction

endpackage

// File: rtl/sab_lfsr.sv
module sab_lfsr #(
    parameter int          W    = 16,
    parameter logic [15:0] SEED = 16'hACE1,
    parameter logic [15:0] TAPS = 16'hB400
) (
    input  logic         clk,
    input  logic         rst,
    output logic [W-1:0] state
);
    logic fb;

    always_comb fb = ^(state & W'(TAPS));

    always_ff @(posedge clk) begin
        if (rst) state <= W'(SEED);
        else     state <= {state[W-2:0], fb};
    end

    // R11: generator never locks up in the all-zero state
    p_lfsr_live_r11: assert property (@(posedge clk) disable iff (rst)
        state != '0);

endmodule

// File: rtl/sab_window.sv
module sab_window #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] start,
    input  logic [CW-1:0] len,
    input  logic          perm,
    input  logic          hold,
    output logic          active,
    output logic          first
);
    logic [CW-1:0] tick;
    logic          active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tick     <= '0;
            active_q <= 1'b0;
        end else begin
            tick     <= tick + 1'b1;
            active_q <= active;
        end
    end

    always_comb begin
        active = (tick >= start) && (perm || ((tick - start) < len));
        first  = active && !active_q;
    end

    // R3: a permanent fault stays live while its settings are untouched
    p_perm_keep_r3: assert property (@(posedge clk) disable iff (rst)
        (active && perm && !hold) |=> active);

    // R2: the first-cycle marker never lasts two cycles
    p_first_once_r2: assert property (@(posedge clk) disable iff (rst)
        first |=> !first);

endmodule

// File: rtl/sab_delay_line.sv
module sab_delay_line #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int SW   = $clog2(DEPTH + 1),
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  din,
    input  logic [SW-1:0] sel,
    output logic [W-1:0]  dout
);
    logic [W-1:0] stg [DEPTH];

    for (genvar k = 0; k < DEPTH; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= '0;
                else     stg[k] <= stg[k-1];
            end
        end
    end

    logic [SW-1:0] idx;

    always_comb begin
        idx  = sel - SW'(1);
        dout = (sel == '0) ? din : stg[AW'(idx)];
    end

endmodule

// File: rtl/sab_int_path.sv
module sab_int_path
    import sab_pkg::*;
#(
    parameter int IW   = 16,
    parameter int FRAC = 8,
    parameter int RW   = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 active,
    input  logic                 first,
    input  ifx_e                 ifx,
    input  logic signed [IW-1:0] opa,
    input  logic signed [IW-1:0] opb,
    input  logic        [RW-1:0] rnd,
    input  logic signed [IW-1:0] din,
    input  logic signed [IW-1:0] dly,
    output logic signed [IW-1:0] dout
);
    localparam int WW = 2 * IW + 2;
    localparam logic signed [WW-1:0] HI = (WW'(1) <<< (IW - 1)) - WW'(1);
    localparam logic signed [WW-1:0] LO = -HI - WW'(1);

    function automatic logic signed [IW-1:0] clip(input logic signed [WW-1:0] v);
        if (v > HI)      return HI[IW-1:0];
        else if (v < LO) return LO[IW-1:0];
        else             return v[IW-1:0];
    endfunction

    logic signed [IW-1:0] held, acc, acc_nx, pick;
    logic signed [WW-1:0] x_in, x_a, x_pick, span, prod_a, prod_p;
    logic        [WW-1:0] span_u, ofs_u;
    logic                 range_ok;

    always_comb begin
        x_in     = WW'(din);
        x_a      = WW'(opa);
        range_ok = opb >= opa;
        span     = WW'(opb) - x_a + WW'(1);
        span_u   = range_ok ? unsigned'(span) : WW'(1);
        ofs_u    = range_ok ? (WW'(rnd) % span_u) : '0;
        x_pick   = x_a + signed'(ofs_u);
        pick     = x_pick[IW-1:0];
        prod_a   = (x_in * x_a) >>> FRAC;
        prod_p   = (x_in * WW'(pick)) >>> FRAC;
        acc_nx   = clip(WW'(acc) + x_a);
    end

    always_comb begin
        dout = din;
        if (active) begin
            unique case (ifx)
                IFX_CONST:      dout = opa;
                IFX_GAIN:       dout = clip(prod_a);
                IFX_GAIN_RND:   dout = clip(prod_p);
                IFX_DRIFT:      dout = clip(x_in + WW'(acc_nx));
                IFX_OFFSET:     dout = clip(x_in + x_a);
                IFX_OFFSET_RND: dout = clip(x_in + WW'(pick));
                IFX_HOLD:       dout = first ? din : held;
                IFX_RANDOM:     dout = pick;
                IFX_DELAY:      dout = dly;
                default:        dout = din;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
            acc  <= '0;
        end else begin
            if (first) held <= din;
            if (active && ifx == IFX_DRIFT) acc <= acc_nx;
            else                            acc <= '0;
        end
    end

    // R12: a frozen integer does not move after its first live cycle
    p_hold_still_r12: assert property (@(posedge clk) disable iff (rst)
        (active && !first && ifx == IFX_HOLD && $past(ifx) == IFX_HOLD)
        |-> dout == $past(dout));

    // R11: random values stay inside the programmed bounds
    p_rand_bound_r11: assert property (@(posedge clk) disable iff (rst)
        (active && ifx == IFX_RANDOM && opb >= opa) |-> (dout >= opa && dout <= opb));

endmodule

// File: rtl/sig_saboteur.sv
module sig_saboteur
    import sab_pkg::*;
#(
    parameter int IW      = 16,
    parameter int CW      = 32,
    parameter int MAXD    = 16,
    parameter int FRAC    = 8,
    parameter int RNDW    = 16,
    localparam int SW     = $clog2(MAXD + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [31:0]          cfg_wdata,
    input  logic                 cond_in,
    input  logic                 b_in,
    output logic                 b_out,
    input  logic signed [IW-1:0] i_in,
    output logic signed [IW-1:0] i_out
);
    ctrl_t                ctrl_q;
    logic [CW-1:0]        start_q, len_q;
    logic signed [IW-1:0] opa_q, opb_q;
    logic [31:0]          dly_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= decode_ctrl('0);
            start_q <= '0;
            len_q   <= '0;
            opa_q   <= '0;
            opb_q   <= '0;
            dly_q   <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                ADDR_CTRL:  ctrl_q  <= decode_ctrl(cfg_wdata[11:0]);
                ADDR_START: start_q <= cfg_wdata[CW-1:0];
                ADDR_LEN:   len_q   <= cfg_wdata[CW-1:0];
                ADDR_OPA:   opa_q   <= cfg_wdata[IW-1:0];
                ADDR_OPB:   opb_q   <= cfg_wdata[IW-1:0];
                ADDR_DELAY: dly_q   <= cfg_wdata;
                default: ;
            endcase
        end
    end

    logic            win_active, win_first;
    logic [RNDW-1:0] rnd;
    logic [SW-1:0]   dsel;

    always_comb dsel = (dly_q > 32'(MAXD)) ? SW'(MAXD) : SW'(dly_q);

    sab_window #(.CW(CW)) u_win (
        .clk(clk), .rst(rst), .start(start_q), .len(len_q), .perm(ctrl_q.perm),
        .hold(cfg_we), .active(win_active), .first(win_first)
    );

    sab_lfsr #(.W(RNDW)) u_rng (.clk(clk), .rst(rst), .state(rnd));

    // flag channel
    logic b_dly, b_held, b_live;

    sab_delay_line #(.W(1), .DEPTH(MAXD)) u_bdly (
        .clk(clk), .rst(rst), .din(b_in), .sel(dsel), .dout(b_dly)
    );

    always_comb begin
        b_live = win_active && ctrl_q.en_b;
        b_out  = b_in;
        if (b_live) begin
            unique case (ctrl_q.bfx)
                BFX_INVERT:   b_out = ~b_in;
                BFX_FORCE:    b_out = opa_q[0];
                BFX_HOLD:     b_out = win_first ? b_in : b_held;
                BFX_FORCE_IF: b_out = cond_in ? opa_q[0] : b_in;
                BFX_NOISE:    b_out = rnd[0];
                BFX_DELAY:    b_out = b_dly;
                default:      b_out = b_in;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            b_held <= 1'b0;
        else if (win_first) b_held <= b_in;
    end

    // integer channel
    logic signed [IW-1:0] i_dly;
    logic [IW-1:0]        i_dly_raw;

    sab_delay_line #(.W(IW), .DEPTH(MAXD)) u_idly (
        .clk(clk), .rst(rst), .din(i_in), .sel(dsel), .dout(i_dly_raw)
    );

    always_comb i_dly = signed'(i_dly_raw);

    sab_int_path #(.IW(IW), .FRAC(FRAC), .RW(RNDW)) u_ipath (
        .clk(clk), .rst(rst), .active(win_active && ctrl_q.en_i),
        .first(win_first), .ifx(ctrl_q.ifx), .opa(opa_q), .opb(opb_q),
        .rnd(rnd), .din(i_in), .dly(i_dly), .dout(i_out)
    );

    // R1: idle path is transparent on both channels
    p_idle_pass_r1: assert property (@(posedge clk) disable iff (rst)
        !win_active |-> (b_out == b_in && i_out == i_in));

    // R4: inversion always differs from the input
    p_invert_r4: assert property (@(posedge clk) disable iff (rst)
        (b_live && ctrl_q.bfx == BFX_INVERT) |-> b_out != b_in);

    // R4: gated force is transparent while its condition is low
    p_cond_low_r4: assert property (@(posedge clk) disable iff (rst)
        (b_live && ctrl_q.bfx == BFX_FORCE_IF && !cond_in) |-> b_out == b_in);

endmodule

// File: tb/sig_saboteur_test.sv
`timescale 1ns/1ps
module sig_saboteur_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        cond_in = 1'b0;
    logic        b_in = 1'b0;
    logic        b_out;
    logic signed [15:0] i_in = '0;
    logic signed [15:0] i_out;

    int nchk = 0;
    int nerr = 0;
    int cyc  = 0;
    logic bh [4096];
    int   ih [4096];

    sig_saboteur uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cond_in(cond_in), .b_in(b_in), .b_out(b_out),
        .i_in(i_in), .i_out(i_out)
    );

    always #10 clk = ~clk;

    initial for (int k = 0; k < 4096; k++) begin bh[k] = 1'b0; ih[k] = 0; end

    always @(posedge clk) if (!rst) begin
        bh[cyc % 4096] <= b_in;
        ih[cyc % 4096] <= int'(i_in);
        cyc <= cyc + 1;
    end

    function automatic int clip(input longint v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int fxmul(input int a, input int g);
        longint p;
        p = longint'(a) * longint'(g);
        return clip(p >>> 8);
    endfunction

    function automatic int pat(input int k);
        return ((k * 1237 + 55) % 4001) - 2000;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic step(input logic b, input int i);
        @(negedge clk);
        b_in = b; i_in = 16'(i);
        #5;
    endtask

    // ctrl: en_b bit0, en_i bit1, perm bit2, flag code 6:4, int code 11:8
    function automatic logic [31:0] ctl(input bit eb, input bit ei, input bit pm,
                                        input int bf, input int fx);
        return 32'(eb) | (32'(ei) << 1) | (32'(pm) << 2) | (32'(bf) << 4) | (32'(fx) << 8);
    endfunction

    task automatic setup(input logic [31:0] c, input int len, input int a, input int b,
                         input int d, output int s);
        wr(3'd0, 32'd0);
        wr(3'd2, 32'(len));
        wr(3'd3, 32'(a));
        wr(3'd4, 32'(b));
        wr(3'd5, 32'(d));
        s = cyc + 8;
        wr(3'd1, 32'(s));
        wr(3'd0, c);
        while (cyc < s - 3) step(1'b0, 0);
    endtask

    int  s;
    bit  live;
    int  hv, ex;
    logic hb, eb;
    int  ones, zeros, lo, hi, first_v, distinct;

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state: transparent (R1)
        for (int k = 0; k < 6; k++) begin
            step(k[0], pat(k));
            chk(b_out == b_in && i_out == i_in, "R1 reset pass-through", i_out, i_in);
        end

        // invert, transient, length 4; integer disabled (R2 R4 R1)
        setup(ctl(1, 0, 0, 0, 0), 4, 0, 0, 0, s);
        for (int k = -2; k < 8; k++) begin
            step(cyc[0] ^ cyc[2], pat(cyc));
            live = (cyc >= s) && (cyc < s + 4);
            eb = live ? ~b_in : b_in;
            chk(b_out == eb, "R2 R4 invert window", b_out, eb);
            chk(i_out == i_in, "R1 disabled integer passes", i_out, i_in);
        end

        // force to 1, permanent (R3)
        setup(ctl(1, 0, 1, 1, 0), 2, 1, 0, 0, s);
        for (int k = -1; k < 20; k++) begin
            step(1'b0, 0);
            eb = (cyc >= s) ? 1'b1 : 1'b0;
            chk(b_out == eb, "R3 permanent force", b_out, eb);
        end

        // gated force to 0 (R4)
        setup(ctl(1, 0, 0, 3, 0), 12, 0, 0, 0, s);
        for (int k = 0; k < 14; k++) begin
            cond_in = (k % 3 == 0);
            step(1'b1, 0);
            live = (cyc >= s) && (cyc < s + 12);
            eb = (live && cond_in) ? 1'b0 : 1'b1;
            chk(b_out == eb, "R4 gated force", b_out, eb);
        end
        cond_in = 1'b0;

        // flag freeze (R5)
        setup(ctl(1, 0, 0, 2, 0), 7, 0, 0, 0, s);
        for (int k = -1; k < 9; k++) begin
            step(cyc[0] ^ cyc[1], 0);
            if (cyc == s) hb = b_in;
            live = (cyc >= s) && (cyc < s + 7);
            eb = live ? hb : b_in;
            chk(b_out == eb, "R5 flag freeze", b_out, eb);
        end

        // noise (R6)
        setup(ctl(1, 0, 0, 4, 0), 40, 0, 0, 0, s);
        ones = 0; zeros = 0;
        while (cyc < s) step(1'b0, 0);
        for (int k = 0; k < 40; k++) begin
            step(1'b0, 0);
            if (b_out) ones++; else zeros++;
        end
        chk(ones > 0 && zeros > 0, "R6 noise takes both values", ones, 1);

        // delays: 3 and 40 (limited to 16), both channels (R7)
        for (int t = 0; t < 3; t++) begin
            hv = (t == 0) ? 3 : (t == 1) ? 40 : 0;
            setup(ctl(1, 1, 0, 5, 8), 30, 0, 0, hv, s);
            ex = (hv > 16) ? 16 : hv;
            for (int k = 0; k < 34; k++) begin
                step(cyc[0] ^ cyc[3], pat(cyc));
                live = (cyc >= s) && (cyc < s + 30);
                eb = live ? ((ex == 0) ? b_in : bh[(cyc - ex) % 4096]) : b_in;
                hv = live ? ((ex == 0) ? int'(i_in) : ih[(cyc - ex) % 4096]) : int'(i_in);
                chk(b_out == eb && int'(i_out) == hv, "R7 delay", i_out, hv);
            end
        end

        // constant and offset with clipping (R8)
        setup(ctl(0, 1, 1, 0, 0), 0, -1234, 0, 0, s);
        for (int k = 0; k < 6; k++) begin
            step(1'b0, pat(k * 7));
            chk(int'(i_out) == ((cyc >= s) ? -1234 : int'(i_in)), "R8 constant", i_out, -1234);
        end
        setup(ctl(0, 1, 1, 0, 4), 0, 300, 0, 0, s);
        while (cyc < s) step(1'b0, 0);
        for (int v = -32768; v < 32768; v += 613) begin
            step(1'b0, v);
            ex = clip(longint'(v) + 300);
            chk(int'(i_out) == ex, "R8 offset clip", i_out, ex);
        end
        step(1'b0, 32700);
        chk(int'(i_out) == 32767, "R8 offset top clip", i_out, 32767);

        // fixed gain 1.5 and -2.0 (R9)
        for (int t = 0; t < 2; t++) begin
            hv = (t == 0) ? 384 : -512;
            setup(ctl(0, 1, 1, 0, 1), 0, hv, 0, 0, s);
            while (cyc < s) step(1'b0, 0);
            for (int v = -32768; v < 32768; v += 331) begin
                step(1'b0, v);
                ex = fxmul(v, hv);
                chk(int'(i_out) == ex, "R9 gain", i_out, ex);
            end
            step(1'b0, -3);
            ex = fxmul(-3, hv);
            chk(int'(i_out) == ex, "R9 gain floor odd", i_out, ex);
        end

        // drift +3 over 6 cycles, then -9000 to bottom clip (R10)
        for (int t = 0; t < 2; t++) begin
            hv = (t == 0) ? 3 : -9000;
            setup(ctl(0, 1, 0, 0, 3), 6, hv, 0, 0, s);
            for (int k = -1; k < 8; k++) begin
                step(1'b0, pat(cyc));
                live = (cyc >= s) && (cyc < s + 6);
                ex = live ? clip(longint'(i_in) + clip(longint'(cyc - s + 1) * hv)) : int'(i_in);
                chk(int'(i_out) == ex, "R10 drift", i_out, ex);
            end
        end

        // random value in [-5,10], reversed range gives A (R11)
        setup(ctl(0, 1, 1, 0, 7), 0, -5, 10, 0, s);
        while (cyc < s) step(1'b0, 0);
        lo = 99; hi = -99;
        for (int k = 0; k < 60; k++) begin
            step(1'b0, 0);
            if (int'(i_out) < lo) lo = int'(i_out);
            if (int'(i_out) > hi) hi = int'(i_out);
            chk(i_out >= -5 && i_out <= 10, "R11 random bounds", i_out, -5);
        end
        chk(hi > lo, "R11 random varies", hi - lo, 1);
        setup(ctl(0, 1, 1, 0, 7), 0, 20, 4, 0, s);
        while (cyc < s) step(1'b0, 0);
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 0);
            chk(int'(i_out) == 20, "R11 reversed range", i_out, 20);
        end

        // random offset [-50,50] and random gain [1.0,2.0] (R11)
        setup(ctl(0, 1, 1, 0, 5), 0, -50, 50, 0, s);
        while (cyc < s) step(1'b0, 0);
        for (int k = 0; k < 40; k++) begin
            step(1'b0, pat(k));
            chk(int'(i_out) >= int'(i_in) - 50 && int'(i_out) <= int'(i_in) + 50,
                "R11 random offset", i_out, i_in);
        end
        setup(ctl(0, 1, 1, 0, 2), 0, 256, 512, 0, s);
        while (cyc < s) step(1'b0, 0);
        for (int k = 0; k < 40; k++) begin
            step(1'b0, 100 + k * 300);
            chk(int'(i_out) >= int'(i_in) && int'(i_out) <= clip(2 * longint'(i_in)),
                "R11 random gain", i_out, i_in);
        end

        // integer freeze (R12)
        setup(ctl(0, 1, 0, 0, 6), 5, 0, 0, 0, s);
        for (int k = -1; k < 7; k++) begin
            step(1'b0, pat(cyc));
            if (cyc == s) first_v = int'(i_in);
            live = (cyc >= s) && (cyc < s + 5);
            ex = live ? first_v : int'(i_in);
            chk(int'(i_out) == ex, "R12 integer freeze", i_out, ex);
        end

        // shared window (R13)
        setup(ctl(1, 1, 0, 0, 0), 5, 777, 0, 0, s);
        for (int k = -2; k < 7; k++) begin
            step(cyc[1], pat(cyc));
            live = (cyc >= s) && (cyc < s + 5);
            eb = live ? ~b_in : b_in;
            ex = live ? 777 : int'(i_in);
            chk(b_out == eb && int'(i_out) == ex, "R13 shared window", i_out, ex);
        end

        // enables clear with codes set; undefined codes pass (R14)
        setup(ctl(0, 0, 1, 0, 0), 0, 5, 0, 0, s);
        distinct = 0;
        while (cyc < s) step(1'b0, 0);
        for (int k = 0; k < 6; k++) begin
            step(k[0], pat(k));
            chk(b_out == b_in && i_out == i_in, "R14 enables clear", i_out, i_in);
        end
        setup(ctl(1, 1, 1, 7, 15), 0, 5, 0, 0, s);
        while (cyc < s) step(1'b0, 0);
        for (int k = 0; k < 6; k++) begin
            step(k[0], pat(k + 3));
            chk(b_out == b_in && i_out == i_in, "R14 undefined codes", i_out, i_in);
        end

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule